// File: doc/BRIEF.md
# Memory-Mapped Message Port

This block sits between a processor's register bus and a packet network. It has one outgoing word FIFO and one incoming word FIFO. Software builds an outgoing message with two kinds of write. The first is an opening write, which carries the destination, the tag and the word count, and whose address selects one of four operations. After it come plain data writes, one for each data word. The message goes into the outgoing FIFO only when it is complete and only if all of its words fit. Afterwards software reads a flag that tells it whether to retry.

On the receive side, the first word of each incoming message is a header, and its low bits give the count of data words that follow. The block takes the header off the incoming FIFO by itself. It then reports that a message is pending and how many of its words are still unread. Each read of the data register pops the next word.

A header whose interrupt bit is set raises a one-cycle interrupt pulse. Incorrect use of the send side and reads with nothing to return are reported in status bits.

Top module: `msg_port`

## Requirements
- R1: After reset the status register reads 0, the free-space register reads TX_DEPTH, the remaining-length register reads 0, tx_valid_o and irq_o are low and rx_ready_o is high.
- R2: An opening write (address 0x8 + op, op = addr[1:0]) with word count L = wdata[2:0] in 1..5, followed by L data writes (address 0x0), emits L+1 words on the tx port. The first word is the header {wdata[31:5], op, L}. The data words follow in write order. Status bit 0 (send ok) is then 1.
- R3: A message is sent whole or not at all. If, in the cycle of its last data write, the free space (not counting a word leaving in that same cycle) is below L+1, no word is emitted and send ok becomes 0.
- R4: A data write with no open message (no opening write, or after the declared count is reached) sets status bit 2 (send error) and emits nothing. A valid opening write clears bit 2.
- R5: An opening write with L = 0 or L > 5 sets bit 2, clears bit 0 and leaves no message open.
- R6: The free-space register (address 0x2) reads TX_DEPTH minus the number of words held in the outgoing FIFO.
- R7: Once an incoming header (count in bits [2:0]) has been taken, status bit 1 (receive ok) is 1 and address 0x3 gives the unread count. Each read of address 0x0 returns the next data word in arrival order and lowers the count by one. At zero, bit 1 drops and the next header is taken.
- R8: A read of address 0x0 with no data word available returns 0, does not change the unread count, and sets status bit 3 (underflow), which stays set until reset.
- R9: irq_o pulses high for one cycle when a header with bit 15 set and a nonzero count is taken.
- R10: rx_ready_o is low while the incoming FIFO holds RX_DEPTH words, and a word offered then is not taken.
- R11: An opening write while a message is still open discards the words already written for it.
- R12: An incoming word may be accepted in the same cycle as a data read pops another word, and a commit may happen in the same cycle as a tx word leaves. Neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access in this cycle |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | AW | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| tx_valid_o | output | 1 | Outgoing word available |
| tx_data_o | output | 32 | Outgoing word |
| tx_ready_i | input | 1 | Network takes the outgoing word |
| rx_valid_i | input | 1 | Incoming word offered |
| rx_data_i | input | 32 | Incoming word |
| rx_ready_o | output | 1 | Incoming FIFO has room |
| irq_o | output | 1 | Interrupt pulse for a flagged header |

## Verification
There are two same-cycle collisions. On the receive side, a data-register read pops a word while the network pushes the next word of the same message. The bench drives both in one cycle and checks three things: the returned word is the older one, the unread count is right, and no underflow is flagged. On the send side, the final data write commits a message while the network drains a word. The bench raises tx_ready_i in that cycle and checks that the head word leaves intact, that the commit is accepted and that the free-space register then reads one more than the committed size alone would give.

// File: rtl/msg_port_pkg.sv
package msg_port_pkg;
  localparam int unsigned MSG_DW   = 32;
  localparam int unsigned MSG_MAXW = 5;
  localparam int unsigned OP_LSB   = 3;
  localparam int unsigned IRQ_BIT  = 15;

  localparam int unsigned ST_SEND_OK = 0;
  localparam int unsigned ST_RX_OK   = 1;
  localparam int unsigned ST_ERR     = 2;
  localparam int unsigned ST_UFLOW   = 3;

  localparam logic [1:0] REGION_REG   = 2'd0;
  localparam logic [1:0] REGION_FIRST = 2'd2;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_SPACE = 2'd2,
    SEL_LEFT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NW    = 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned NCW  = $clog2(NW + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCW-1:0]         wr_cnt_i,
  input  logic [NW-1:0][DW-1:0]  wr_data_i,
  input  logic                   rd_en_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [CW-1:0]          count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  // caller guarantees wr_cnt_i fits and rd_en_i only when not empty
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(NW); i++) begin
      if (i < int'(wr_cnt_i)) mem_q[wptr_q + AW'(i)] <= wr_data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(wr_cnt_i);
      rptr_q <= rptr_q + AW'(rd_en_i);
      cnt_q  <= cnt_q + CW'(wr_cnt_i) - CW'(rd_en_i);
    end
  end

  assign rd_data_o = mem_q[rptr_q];
  assign count_o   = cnt_q;
endmodule

// File: rtl/msg_send_stage.sv
module msg_send_stage
  import msg_port_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned MAXW = 5,
  parameter int unsigned CW   = 5,
  localparam int unsigned LW  = $clog2(MAXW + 1),
  localparam int unsigned NCW = $clog2(MAXW + 2)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    first_we_i,
  input  logic                    send_we_i,
  input  logic [1:0]              op_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [CW-1:0]           free_i,
  output logic [NCW-1:0]          push_cnt_o,
  output logic [MAXW:0][DW-1:0]   push_data_o,
  output logic                    send_ok_o,
  output logic                    err_o
);
  logic                       open_q, ok_q, err_q;
  logic [LW-1:0]              need_q, cnt_q;
  logic [DW-1:0]              hdr_q;
  logic [MAXW-1:0][DW-1:0]    buf_q;

  logic [LW-1:0] len_w;
  logic          len_ok, last_w, fits_w, commit_w;

  assign len_w    = wdata_i[LW-1:0];
  assign len_ok   = (len_w != '0) && (len_w <= LW'(MAXW));
  assign last_w   = send_we_i && open_q && ((cnt_q + LW'(1)) == need_q);
  assign fits_w   = (CW'(need_q) + CW'(1)) <= free_i;
  assign commit_w = last_w && fits_w;

  always_comb begin
    push_cnt_o     = commit_w ? (NCW'(need_q) + NCW'(1)) : '0;
    push_data_o[0] = hdr_q;
    for (int i = 1; i <= int'(MAXW); i++) begin
      push_data_o[i] = (need_q == LW'(i)) ? wdata_i : buf_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      need_q <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      buf_q  <= '0;
    end else if (first_we_i) begin
      open_q <= len_ok;
      need_q <= len_w;
      cnt_q  <= '0;
      hdr_q  <= wdata_i;
      hdr_q[OP_LSB +: 2] <= op_i;
      err_q  <= !len_ok;
      if (!len_ok) ok_q <= 1'b0;
    end else if (send_we_i) begin
      if (!open_q) begin
        err_q <= 1'b1;
      end else begin
        buf_q[cnt_q] <= wdata_i;
        cnt_q        <= cnt_q + LW'(1);
        if (last_w) begin
          open_q <= 1'b0;
          ok_q   <= fits_w;
        end
      end
    end
  end

  assign send_ok_o = ok_q;
  assign err_o     = err_q;
endmodule

// File: rtl/msg_recv_ctrl.sv
module msg_recv_ctrl
  import msg_port_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  head_i,
  input  logic           empty_i,
  input  logic           rd_req_i,
  output logic           pop_o,
  output logic [DW-1:0]  rd_data_o,
  output logic           active_o,
  output logic [LW-1:0]  left_o,
  output logic           uflow_o,
  output logic           irq_o
);
  logic          active_q, uflow_q;
  logic [LW-1:0] left_q;
  logic          hdr_load, data_ok;

  assign hdr_load  = !active_q && !empty_i;
  assign data_ok   = rd_req_i && active_q && !empty_i;
  assign pop_o     = hdr_load || data_ok;
  assign rd_data_o = data_ok ? head_i : '0;
  assign irq_o     = hdr_load && head_i[IRQ_BIT] && (head_i[LW-1:0] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      uflow_q  <= 1'b0;
      left_q   <= '0;
    end else begin
      if (hdr_load) begin
        left_q   <= head_i[LW-1:0];
        active_q <= head_i[LW-1:0] != '0;
      end else if (data_ok) begin
        left_q <= left_q - LW'(1);
        if (left_q == LW'(1)) active_q <= 1'b0;
      end
      if (rd_req_i && !data_ok) uflow_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign left_o   = left_q;
  assign uflow_o  = uflow_q;
endmodule

// File: rtl/msg_port.sv
module msg_port
  import msg_port_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_write_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          tx_valid_o,
  output logic [31:0]   tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [31:0]   rx_data_i,
  output logic          rx_ready_o,
  output logic          irq_o
);
  localparam int unsigned RW   = AW - 2;
  localparam int unsigned TCW  = $clog2(TX_DEPTH + 1);
  localparam int unsigned RCW  = $clog2(RX_DEPTH + 1);
  localparam int unsigned LW   = $clog2(MSG_MAXW + 1);
  localparam int unsigned PCW  = $clog2(MSG_MAXW + 2);

  logic [RW-1:0] region;
  reg_sel_e      sel;
  logic          reg_hit, first_we, send_we, rd_recv;

  assign region   = bus_addr_i[AW-1:2];
  assign sel      = reg_sel_e'(bus_addr_i[1:0]);
  assign reg_hit  = bus_valid_i && (region == RW'(REGION_REG));
  assign first_we = bus_valid_i && bus_write_i && (region == RW'(REGION_FIRST));
  assign send_we  = reg_hit && bus_write_i && (sel == SEL_DATA);
  assign rd_recv  = reg_hit && !bus_write_i && (sel == SEL_DATA);

  // send path
  logic [TCW-1:0]                 tx_cnt, tx_free;
  logic [PCW-1:0]                 tx_push_cnt;
  logic [MSG_MAXW:0][MSG_DW-1:0]  tx_push_data;
  logic                           send_ok, send_err, tx_pop;

  assign tx_free    = TCW'(TX_DEPTH) - tx_cnt;
  assign tx_valid_o = tx_cnt != '0;
  assign tx_pop     = tx_valid_o && tx_ready_i;

  msg_send_stage #(.DW(MSG_DW), .MAXW(MSG_MAXW), .CW(TCW)) i_send (
    .clk_i, .rst_ni,
    .first_we_i (first_we),
    .send_we_i  (send_we),
    .op_i       (bus_addr_i[1:0]),
    .wdata_i    (bus_wdata_i),
    .free_i     (tx_free),
    .push_cnt_o (tx_push_cnt),
    .push_data_o(tx_push_data),
    .send_ok_o  (send_ok),
    .err_o      (send_err)
  );

  msg_fifo #(.DW(MSG_DW), .DEPTH(TX_DEPTH), .NW(MSG_MAXW + 1)) i_tx_fifo (
    .clk_i, .rst_ni,
    .wr_cnt_i (tx_push_cnt),
    .wr_data_i(tx_push_data),
    .rd_en_i  (tx_pop),
    .rd_data_o(tx_data_o),
    .count_o  (tx_cnt)
  );

  // receive path
  logic [RCW-1:0]    rx_cnt;
  logic [MSG_DW-1:0] rx_head, rx_word;
  logic              rx_empty, rx_pop, rx_ok, rx_uflow;
  logic [LW-1:0]     rx_left;
  logic [0:0]        rx_push;

  assign rx_ready_o = rx_cnt != RCW'(RX_DEPTH);
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_empty   = rx_cnt == '0;

  msg_fifo #(.DW(MSG_DW), .DEPTH(RX_DEPTH), .NW(1)) i_rx_fifo (
    .clk_i, .rst_ni,
    .wr_cnt_i (rx_push),
    .wr_data_i(rx_data_i),
    .rd_en_i  (rx_pop),
    .rd_data_o(rx_head),
    .count_o  (rx_cnt)
  );

  msg_recv_ctrl #(.DW(MSG_DW), .LW(LW)) i_recv (
    .clk_i, .rst_ni,
    .head_i   (rx_head),
    .empty_i  (rx_empty),
    .rd_req_i (rd_recv),
    .pop_o    (rx_pop),
    .rd_data_o(rx_word),
    .active_o (rx_ok),
    .left_o   (rx_left),
    .uflow_o  (rx_uflow),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (reg_hit && !bus_write_i) begin
      unique case (sel)
        SEL_DATA:  bus_rdata_o = rx_word;
        SEL_STAT: begin
          bus_rdata_o[ST_SEND_OK] = send_ok;
          bus_rdata_o[ST_RX_OK]   = rx_ok;
          bus_rdata_o[ST_ERR]     = send_err;
          bus_rdata_o[ST_UFLOW]   = rx_uflow;
        end
        SEL_SPACE: bus_rdata_o = 32'(tx_free);
        SEL_LEFT:  bus_rdata_o = 32'(rx_left);
        default:   bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/msg_port_chk.sv
module msg_port_chk #(
  parameter int unsigned TCW = 5,
  parameter int unsigned PCW = 3,
  parameter int unsigned LW  = 3,
  parameter int unsigned TX_DEPTH = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [TCW-1:0] tx_cnt,
  input logic [TCW-1:0] tx_free,
  input logic [PCW-1:0] tx_push_cnt,
  input logic           send_ok,
  input logic           tx_valid_o,
  input logic [31:0]    tx_data_o,
  input logic           tx_ready_i,
  input logic           rd_recv,
  input logic           rx_ok,
  input logic           rx_empty,
  input logic [LW-1:0]  rx_left,
  input logic           rx_uflow,
  input logic           irq_o
);
  // R3
  push_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    TCW'(tx_push_cnt) <= tx_free);

  // R6
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= TCW'(TX_DEPTH));

  // R2
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R2
  ok_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_ok) |-> $past(tx_push_cnt != '0));

  // R7
  left_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_recv && rx_ok && !rx_empty) |=> (rx_left == $past(rx_left) - LW'(1)));

  // R8
  uflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_uflow |=> rx_uflow);

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind msg_port msg_port_chk #(
  .TCW(TCW), .PCW(PCW), .LW(LW), .TX_DEPTH(TX_DEPTH)
) i_msg_port_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_cnt     (tx_cnt),
  .tx_free    (tx_free),
  .tx_push_cnt(tx_push_cnt),
  .send_ok    (send_ok),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .tx_ready_i (tx_ready_i),
  .rd_recv    (rd_recv),
  .rx_ok      (rx_ok),
  .rx_empty   (rx_empty),
  .rx_left    (rx_left),
  .rx_uflow   (rx_uflow),
  .irq_o      (irq_o)
);

// File: tb/test_msg_port.sv
module test_msg_port;
  localparam int DEPTH = 16;
  localparam logic [3:0] A_DATA = 4'h0, A_STAT = 4'h1, A_SPACE = 4'h2, A_LEFT = 4'h3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
  logic [31:0] tx_data, rx_data = '0;

  int n_chk = 0, n_err = 0, irq_cnt = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  msg_port i_msg_port (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [31:0] w, input logic [1:0] op);
    return {w[31:5], op, w[2:0]};
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic rd_chk(input string rq, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(rq, d, exp);
  endtask

  task automatic stat_bit(input string rq, input int b, input logic exp);
    logic [31:0] d;
    bus_rd(A_STAT, d);
    chk(rq, {31'b0, d[b]}, {31'b0, exp});
  endtask

  task automatic send_msg(input logic [1:0] op, input logic [31:0] hw, input int n,
                          input logic [31:0] base, input bit ok);
    bus_wr(4'h8 | {2'b00, op}, hw);
    if (ok) exp_q.push_back(hdr(hw, op));
    for (int i = 0; i < n; i++) begin
      bus_wr(A_DATA, base + i);
      if (ok) exp_q.push_back(base + i);
    end
  endtask

  task automatic drain(input string rq, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      chk(rq, {31'b0, tx_valid}, 32'd1);
      chk(rq, tx_data, e);
      tx_ready = 1;
      @(posedge clk); #1;
      tx_ready = 0;
    end
  endtask

  task automatic rx_push(input logic [31:0] w);
    @(negedge clk);
    rx_valid = 1; rx_data = w;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic wait_rx_ok(input string rq);
    logic [31:0] d;
    d = '0;
    for (int i = 0; i < 8 && !d[1]; i++) bus_rd(A_STAT, d);
    chk(rq, {31'b0, d[1]}, 32'd1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rd_chk("R1 status", A_STAT, 32'd0);
    rd_chk("R1 space", A_SPACE, DEPTH);
    rd_chk("R1 left", A_LEFT, 32'd0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_basic_send();
    send_msg(2'd2, 32'hABCD_1003, 3, 32'h1000_0000, 1);
    rd_chk("R2 status ok", A_STAT, 32'd1);
    rd_chk("R6 space after send", A_SPACE, DEPTH - 4);
    drain("R2 tx words", 4);
    rd_chk("R6 space drained", A_SPACE, DEPTH);
  endtask

  task automatic t_stray();
    bus_wr(A_DATA, 32'h5555_0000);
    rd_chk("R4 stray err", A_STAT, 32'd5);
    chk("R4 nothing sent", {31'b0, tx_valid}, 0);
    send_msg(2'd1, 32'h0202_0001, 1, 32'h2000_0000, 1);
    rd_chk("R4 err cleared", A_STAT, 32'd1);
    drain("R4 valid msg", 2);
    bus_wr(A_DATA, 32'h6666_0000);
    rd_chk("R4 excess word err", A_STAT, 32'd5);
    chk("R4 excess not sent", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_badlen();
    bus_wr(4'h8, 32'h0303_0006);
    rd_chk("R5 len6", A_STAT, 32'd4);
    bus_wr(A_DATA, 32'h7777_0000);
    rd_chk("R5 still closed", A_STAT, 32'd4);
    chk("R5 nothing sent", {31'b0, tx_valid}, 0);
    bus_wr(4'h9, 32'h0303_0000);
    rd_chk("R5 len0", A_STAT, 32'd4);
  endtask

  task automatic t_restart();
    bus_wr(4'h8, 32'h0404_0002);
    bus_wr(A_DATA, 32'hDEAD_0001);
    send_msg(2'd3, 32'h0505_0001, 1, 32'h3000_0000, 1);
    rd_chk("R11 ok", A_STAT, 32'd1);
    rd_chk("R11 space", A_SPACE, DEPTH - 2);
    drain("R11 only new msg", 2);
  endtask

  task automatic t_atomic();
    send_msg(2'd0, 32'h0A0A_0005, 5, 32'h4000_0000, 1);
    send_msg(2'd1, 32'h0B0B_0005, 5, 32'h4100_0000, 1);
    rd_chk("R6 space 4", A_SPACE, 4);
    send_msg(2'd2, 32'h0C0C_0005, 5, 32'h4200_0000, 0);
    stat_bit("R3 too big", 0, 0);
    rd_chk("R3 space unchanged", A_SPACE, 4);
    send_msg(2'd3, 32'h0D0D_0003, 3, 32'h4300_0000, 1);
    stat_bit("R3 exact fit", 0, 1);
    rd_chk("R6 space 0", A_SPACE, 0);
    send_msg(2'd0, 32'h0E0E_0001, 1, 32'h4400_0000, 0);
    stat_bit("R3 full", 0, 0);
    drain("R3 drain order", 16);
    chk("R3 no partial", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_tx_simul();
    send_msg(2'd0, 32'h1111_0005, 5, 32'h5000_0000, 1);
    send_msg(2'd0, 32'h1212_0005, 5, 32'h5100_0000, 1);
    bus_wr(4'h9, 32'h1313_0003);
    exp_q.push_back(hdr(32'h1313_0003, 2'd1));
    bus_wr(A_DATA, 32'h5200_0000);
    bus_wr(A_DATA, 32'h5200_0001);
    exp_q.push_back(32'h5200_0000);
    exp_q.push_back(32'h5200_0001);
    exp_q.push_back(32'h5200_0002);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = A_DATA; bus_wdata = 32'h5200_0002;
    chk("R12 head at commit", tx_data, exp_q.pop_front());
    tx_ready = 1;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0; tx_ready = 0;
    stat_bit("R12 commit ok", 0, 1);
    rd_chk("R12 space", A_SPACE, 1);
    drain("R12 drain", 15);
  endtask

  task automatic t_recv();
    rx_push(32'h1234_0002);
    rx_push(32'hAAAA_0001);
    rx_push(32'hAAAA_0002);
    wait_rx_ok("R7 rx ok");
    rd_chk("R7 left 2", A_LEFT, 2);
    rd_chk("R7 word1", A_DATA, 32'hAAAA_0001);
    rd_chk("R7 left 1", A_LEFT, 1);
    rd_chk("R7 word2", A_DATA, 32'hAAAA_0002);
    rd_chk("R7 left 0", A_LEFT, 0);
    stat_bit("R7 rx ok low", 1, 0);
    chk("R9 no irq", irq_cnt, 0);
  endtask

  task automatic t_irq();
    rx_push(32'h0000_8001);
    rx_push(32'hCCCC_0001);
    rx_push(32'h0000_0001);
    rx_push(32'hDDDD_0001);
    wait_rx_ok("R9 msg1");
    rd_chk("R9 data1", A_DATA, 32'hCCCC_0001);
    wait_rx_ok("R9 msg2");
    rd_chk("R9 data2", A_DATA, 32'hDDDD_0001);
    chk("R9 one pulse", irq_cnt, 1);
  endtask

  task automatic t_rx_full();
    rx_push(32'h0000_0005);
    for (int i = 0; i < 5; i++) rx_push(32'hD000_0000 + i);
    rx_push(32'h0000_0005);
    for (int i = 0; i < 5; i++) rx_push(32'hE000_0000 + i);
    rx_push(32'h0000_0005);
    for (int i = 0; i < 4; i++) rx_push(32'hF000_0000 + i);
    @(negedge clk);
    chk("R10 full", {31'b0, rx_ready}, 0);
    rx_push(32'hBAD0_BAD0);
    for (int i = 0; i < 5; i++) rd_chk("R10 d", A_DATA, 32'hD000_0000 + i);
    wait_rx_ok("R10 msg2");
    for (int i = 0; i < 5; i++) rd_chk("R10 e", A_DATA, 32'hE000_0000 + i);
    wait_rx_ok("R10 msg3");
    for (int i = 0; i < 4; i++) rd_chk("R10 f", A_DATA, 32'hF000_0000 + i);
    rd_chk("R10 left 1", A_LEFT, 1);
    rx_push(32'hF000_0004);
    rd_chk("R10 blocked word dropped", A_DATA, 32'hF000_0004);
    stat_bit("R10 no uflow", 3, 0);
  endtask

  task automatic t_rx_simul();
    rx_push(32'h0000_0002);
    rx_push(32'h6100_0001);
    wait_rx_ok("R12 rx msg");
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = A_DATA;
    rx_valid = 1; rx_data = 32'h6100_0002;
    #1 chk("R12 pop during push", bus_rdata, 32'h6100_0001);
    @(posedge clk); #1;
    bus_valid = 0; rx_valid = 0;
    rd_chk("R12 left", A_LEFT, 1);
    rd_chk("R12 pushed word", A_DATA, 32'h6100_0002);
    stat_bit("R12 no uflow", 3, 0);
  endtask

  task automatic t_uflow();
    rd_chk("R8 empty read zero", A_DATA, 32'd0);
    stat_bit("R8 uflow set", 3, 1);
    rx_push(32'h0000_0002);
    rx_push(32'h7100_0001);
    wait_rx_ok("R8 msg");
    rd_chk("R8 word1", A_DATA, 32'h7100_0001);
    rd_chk("R8 missing word zero", A_DATA, 32'd0);
    rd_chk("R8 left kept", A_LEFT, 1);
    rx_push(32'h7100_0002);
    rd_chk("R8 late word", A_DATA, 32'h7100_0002);
    stat_bit("R8 sticky", 3, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic_send();
    t_stray();
    t_badlen();
    t_restart();
    t_atomic();
    t_tx_simul();
    t_recv();
    t_irq();
    t_rx_full();
    t_rx_simul();
    t_uflow();
    done = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      report();
    end
  end
endmodule